// File: doc/BRIEF.md
# Serial Transceiver with Four-Byte Receive Queue

This block is a byte-wide asynchronous serial port for control links and musical-instrument data streams. A host reads and writes it through a small register port with its own select line. Received characters go into a four-entry queue, so the host has time before it must read them. The transmitter has a holding register in front of its shift register, so the host can write the next byte while the current one is still leaving the line.

Framing is fixed at one start bit, eight data bits sent least significant bit first, and one stop bit. A divisor register sets a tick that runs at sixteen times the bit rate. With a suitable core clock this covers 9600, 38400 and 31250 bit/s. Two handshake lines, ready-to-receive out and clear-to-send in, are both active high. They take effect only when a control bit enables them, so they can be left off for the instrument link. One interrupt output combines a receive-data source and a transmit-holding-empty source, and each source has its own enable.

Register map (2-bit address): 0 = data (a read pops the queue, a write loads the holding register), 1 = status, 2 = control, 3 = divisor. Status bits: 0 receive data available, 1 queue full, 2 holding register empty, 3 transmitter fully idle (holding empty and shifter idle), 4 overrun, 5 framing error, 6 synchronized clear-to-send level, 7 zero. Control bits: 0 receive interrupt enable, 1 transmit interrupt enable, 2 handshake enable. All other control bits read as zero.

Top module: `sio_core`

## Requirements
- R1: After reset, tx_o is 1, irq_o is 0, rts_o is 1, control reads 0, divisor reads DIV_RST (103), and status reads 0x0C, plus bit 6 when cts_i is high.
- R2: A frame on rx_i (low start bit, eight data bits LSB first, high stop bit, each 16*(divisor+1) clocks long) is sampled at the bit midpoints. The byte becomes readable at the data address, and reading it pops it.
- R3: Up to four received bytes are held and read back oldest first. Status bit 1 is set while four are held.
- R4: A byte that completes while four are held is dropped and sets status bit 4. The bit stays set until the status register is read.
- R5: A frame whose stop bit is sampled low is discarded and sets status bit 5. The bit stays set until the status register is read.
- R6: A data write fills the holding register. The transmitter sends it as start, eight data bits LSB first and stop, and the holding register is free again once the shifter has taken the byte. A second byte written during the first goes out right after it.
- R7: A data write while the holding register is full is ignored.
- R8: irq_o = (control bit 0 AND data available) OR (control bit 1 AND holding register empty).
- R9: With handshake enabled, rts_o is 0 while the queue holds four bytes. With handshake disabled, rts_o stays 1.
- R10: With handshake enabled, no new byte starts while cts_i is low, and a pending byte starts once cts_i goes high. With handshake disabled, cts_i is ignored.
- R11: Reading the data address while the queue is empty returns 0 and changes no state.
- R12: The divisor register reads back the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_i | input | 1 | Register port select |
| wr_i | input | 1 | Write strobe (with cs_i) |
| rd_i | input | 1 | Read strobe (with cs_i); a read of address 0 pops the queue |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register, 0 when not selected |
| irq_o | output | 1 | Combined interrupt request |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| cts_i | input | 1 | Clear-to-send, high means the far end may receive |
| rts_o | output | 1 | Ready-to-receive, high means space for incoming data |

## Verification
The receiver is given alternating, walking and all-ones patterns, so a bit-order or sampling-offset error shows up as a wrong byte. A burst of five frames with no read in between separates correct queue ordering from overrun handling and shows when the ready line drops. A frame with a low stop bit is checked against a clean frame, which separates rejection from acceptance. On the transmit side, two back-to-back writes plus a third write while full show double buffering, the gap between frames and the ignored write. The same byte is then sent with handshake on and clear-to-send held low, and with handshake off, to separate gating from bypass.

// File: rtl/sio_pkg.sv
// Shared definitions for the serial transceiver: register addresses,
// bit positions and the serializer state type.
package sio_pkg;
    localparam int DATA_W   = 8;
    localparam int OVS      = 16;                  // ticks per bit
    localparam int TCNT_W   = $clog2(OVS);
    localparam int MID_TICK = OVS / 2 - 1;

    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_CTRL = 2'd2;
    localparam logic [1:0] A_DIV  = 2'd3;

    localparam int C_RXIE = 0;
    localparam int C_TXIE = 1;
    localparam int C_HS   = 2;
    localparam int CTRL_W = 3;

    typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} ser_state_t;
endpackage

// File: rtl/sio_baud.sv
// Oversampling tick generator: one-cycle pulse every (div_i+1) clocks.
// Assumes div_i may change at any time; the counter simply restarts.
module sio_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    // Count clocks and emit a tick at the divisor limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q >= div_i) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_o <= 1'b0;
        end
    end
endmodule

// File: rtl/sio_rx.sv
// 8N1 receiver at 16x oversampling. Validates the start bit at its midpoint,
// samples data bits at their midpoints, and reports either a good byte or a
// framing error at the stop-bit midpoint. Assumes rx_i is already synchronized.
module sio_rx
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rx_i,
    output logic              valid_o,
    output logic              ferr_o,
    output logic [DATA_W-1:0] data_o
);
    ser_state_t        state_q;
    logic [TCNT_W-1:0] tcnt_q;
    logic [2:0]        bcnt_q;

    // Frame state machine driven by the oversampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tcnt_q  <= '0;
            bcnt_q  <= '0;
            data_o  <= '0;
            valid_o <= 1'b0;
            ferr_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            ferr_o  <= 1'b0;
            if (tick_i) begin
                unique case (state_q)
                    ST_IDLE: if (!rx_i) begin
                        state_q <= ST_START;
                        tcnt_q  <= '0;
                    end
                    ST_START: if (tcnt_q == TCNT_W'(MID_TICK)) begin
                        tcnt_q  <= '0;
                        bcnt_q  <= '0;
                        state_q <= rx_i ? ST_IDLE : ST_DATA;
                    end else tcnt_q <= tcnt_q + 1'b1;
                    ST_DATA: if (tcnt_q == TCNT_W'(OVS - 1)) begin
                        tcnt_q <= '0;
                        data_o <= {rx_i, data_o[DATA_W-1:1]};
                        bcnt_q <= bcnt_q + 1'b1;
                        if (bcnt_q == 3'd7) state_q <= ST_STOP;
                    end else tcnt_q <= tcnt_q + 1'b1;
                    ST_STOP: if (tcnt_q == TCNT_W'(OVS - 1)) begin
                        state_q <= ST_IDLE;
                        valid_o <= rx_i;
                        ferr_o  <= !rx_i;
                    end else tcnt_q <= tcnt_q + 1'b1;
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/sio_rxq.sv
// Receive queue: DEPTH-entry first-in first-out store. A push while full and
// a pop while empty are both ignored; the caller decides what a drop means.
module sio_rxq #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic [W-1:0]               din_i,
    input  logic                       pop_i,
    output logic [W-1:0]               dout_o,
    output logic                       full_o,
    output logic                       empty_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign full_o  = (cnt_q == CNT_W'(DEPTH));
    assign empty_o = (cnt_q == '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign dout_o  = mem_q[rptr_q];

    // Store incoming bytes at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem_q[wptr_q] <= din_i;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wptr_q <= (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
            if (do_pop)  rptr_q <= (rptr_q == PTR_W'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
            cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));
    // R11
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o && pop_i && !push_i |=> empty_o);
endmodule

// File: rtl/sio_tx.sv
// 8N1 transmitter shift stage. Loads a byte on start_i when idle, then sends
// start, data LSB first and stop, each bit lasting 16 ticks.
module sio_tx
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              start_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              busy_o,
    output logic              tx_o
);
    ser_state_t        state_q;
    logic [TCNT_W-1:0] tcnt_q;
    logic [2:0]        bcnt_q;
    logic [DATA_W-1:0] sh_q;

    assign busy_o = (state_q != ST_IDLE);

    // Select the line level from the current frame position.
    always_comb begin
        unique case (state_q)
            ST_START: tx_o = 1'b0;
            ST_DATA:  tx_o = sh_q[0];
            default:  tx_o = 1'b1;
        endcase
    end

    // Step through the frame one bit per 16 ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tcnt_q  <= '0;
            bcnt_q  <= '0;
            sh_q    <= '0;
        end else if (state_q == ST_IDLE) begin
            if (start_i) begin
                sh_q    <= data_i;
                tcnt_q  <= '0;
                bcnt_q  <= '0;
                state_q <= ST_START;
            end
        end else if (tick_i) begin
            if (tcnt_q == TCNT_W'(OVS - 1)) begin
                tcnt_q <= '0;
                unique case (state_q)
                    ST_START: state_q <= ST_DATA;
                    ST_DATA: begin
                        sh_q   <= sh_q >> 1;
                        bcnt_q <= bcnt_q + 1'b1;
                        if (bcnt_q == 3'd7) state_q <= ST_STOP;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end else begin
                tcnt_q <= tcnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sio_core.sv
// Serial transceiver top: host register port, holding register, receive
// queue, sticky error flags, handshake and interrupt combination.
// Assumes rx_i and cts_i are asynchronous; both pass a two-flop synchronizer.
module sio_core #(
    parameter int          DIV_W     = 8,
    parameter int          DIV_RST   = 103,
    parameter int          RXQ_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_i,
    input  logic       wr_i,
    input  logic       rd_i,
    input  logic [1:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output logic       irq_o,
    input  logic       rx_i,
    output logic       tx_o,
    input  logic       cts_i,
    output logic       rts_o
);
    import sio_pkg::*;

    logic [1:0]        rx_sync_q, cts_sync_q;
    logic              rx_s, cts_s;
    logic [CTRL_W-1:0] ctrl_q;
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] hold_q, rx_data, q_dout;
    logic              hold_full, ovr_q, ferr_q;
    logic              tick, rx_valid, rx_ferr, q_full, q_empty, tx_busy;
    logic              wr_acc, rd_acc, wr_data, rd_stat, pop, hs_en, tx_go;

    assign rx_s    = rx_sync_q[1];
    assign cts_s   = cts_sync_q[1];
    assign wr_acc  = cs_i && wr_i;
    assign rd_acc  = cs_i && rd_i;
    assign wr_data = wr_acc && (addr_i == A_DATA);
    assign rd_stat = rd_acc && (addr_i == A_STAT);
    assign pop     = rd_acc && (addr_i == A_DATA);
    assign hs_en   = ctrl_q[C_HS];
    assign tx_go   = hold_full && !tx_busy && (!hs_en || cts_s);

    // Bring asynchronous line inputs into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sync_q  <= 2'b11;
            cts_sync_q <= 2'b00;
        end else begin
            rx_sync_q  <= {rx_sync_q[0], rx_i};
            cts_sync_q <= {cts_sync_q[0], cts_i};
        end
    end

    // Host-writable control and divisor registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            div_q  <= DIV_W'(DIV_RST);
        end else if (wr_acc) begin
            if (addr_i == A_CTRL) ctrl_q <= wdata_i[CTRL_W-1:0];
            if (addr_i == A_DIV)  div_q  <= wdata_i[DIV_W-1:0];
        end
    end

    // Transmit holding register: filled by the host, drained by the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
        end else if (tx_go) begin
            hold_full <= 1'b0;
        end else if (wr_data && !hold_full) begin
            hold_q    <= wdata_i;
            hold_full <= 1'b1;
        end
    end

    // Sticky error flags: set by the receiver, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q  <= 1'b0;
            ferr_q <= 1'b0;
        end else begin
            ovr_q  <= (rx_valid && q_full) || (ovr_q && !rd_stat);
            ferr_q <= rx_ferr || (ferr_q && !rd_stat);
        end
    end

    sio_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div_i(div_q), .tick_o(tick));

    sio_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_i(rx_s),
        .valid_o(rx_valid), .ferr_o(rx_ferr), .data_o(rx_data));

    sio_rxq #(.W(DATA_W), .DEPTH(RXQ_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push_i(rx_valid), .din_i(rx_data),
        .pop_i(pop), .dout_o(q_dout), .full_o(q_full), .empty_o(q_empty));

    sio_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .start_i(tx_go),
        .data_i(hold_q), .busy_o(tx_busy), .tx_o(tx_o));

    // Read multiplexer for the addressed register.
    always_comb begin
        rdata_o = '0;
        if (cs_i) begin
            unique case (addr_i)
                A_DATA: rdata_o = q_empty ? '0 : q_dout;
                A_STAT: rdata_o = {1'b0, cts_s, ferr_q, ovr_q,
                                   !hold_full && !tx_busy, !hold_full,
                                   q_full, !q_empty};
                A_CTRL: rdata_o = 8'(ctrl_q);
                default: rdata_o = 8'(div_q);
            endcase
        end
    end

    assign irq_o = (ctrl_q[C_RXIE] && !q_empty) || (ctrl_q[C_TXIE] && !hold_full);
    assign rts_o = !(hs_en && q_full);

    // R4
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && q_full |=> ovr_q);
    // R10
    cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> (!$past(hs_en) || $past(cts_s)));
    // R7
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_full && wr_data && !tx_go |=> hold_full && $stable(hold_q));
endmodule

// File: tb/sio_core_bench.sv
// Bench with a behavioural model: a queue of expected received bytes and
// model flags, from which every expected register value is computed.
module sio_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 3;
    localparam int BIT        = 16 * (DIV + 1);

    logic       clk = 0, rst_n = 0;
    logic       cs_i = 0, wr_i = 0, rd_i = 0, rx_i = 1, cts_i = 1;
    logic [1:0] addr_i = 0;
    logic [7:0] wdata_i = 0;
    logic [7:0] rdata_o;
    logic       irq_o, tx_o, rts_o;

    int total = 0, bad = 0, cyc = 0;
    logic [7:0] mq[$];
    bit m_ovr = 0, m_ferr = 0;

    sio_core u_sio_core (.*);

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic host_wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk); cs_i = 1; wr_i = 1; addr_i = a; wdata_i = d;
        @(negedge clk); cs_i = 0; wr_i = 0;
    endtask

    task automatic host_rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk); cs_i = 1; rd_i = 1; addr_i = a;
        #1 d = rdata_o;
        @(negedge clk); cs_i = 0; rd_i = 0;
    endtask

    function automatic logic [7:0] exp_stat(bit hold_e, bit idle);
        return {1'b0, cts_i, m_ferr, m_ovr, idle, hold_e,
                mq.size() == 4, mq.size() != 0};
    endfunction

    // Drive one frame; a bad stop is held low for part of its bit only.
    task automatic send(logic [7:0] b, bit good);
        @(negedge clk); rx_i = 0; repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin rx_i = b[i]; repeat (BIT) @(negedge clk); end
        rx_i = good;
        repeat (good ? BIT : (BIT * 5) / 8) @(negedge clk);
        rx_i = 1; repeat (BIT) @(negedge clk);
        if (!good) m_ferr = 1;
        else if (mq.size() < 4) mq.push_back(b);
        else m_ovr = 1;
    endtask

    task automatic get_tx(output logic [7:0] b, output int t_fall);
        int w = 0;
        while (tx_o !== 1'b0 && w < 20000) begin @(negedge clk); w++; end
        t_fall = cyc;
        repeat (BIT / 2) @(negedge clk);
        chk("R6 start bit", tx_o, 0);
        for (int i = 0; i < 8; i++) begin repeat (BIT) @(negedge clk); b[i] = tx_o; end
        repeat (BIT) @(negedge clk);
        chk("R6 stop bit", tx_o, 1);
    endtask

    task automatic stat_chk(string req, bit hold_e, bit idle);
        logic [7:0] d;
        host_rd(2'd1, d);
        chk(req, d, exp_stat(hold_e, idle));
        m_ovr = 0; m_ferr = 0;
    endtask

    task automatic run_all();
        logic [7:0] d, b0, b1;
        int t0, t1, hi;
        repeat (4) @(negedge clk); rst_n = 1; repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 tx_o", tx_o, 1); chk("R1 irq_o", irq_o, 0); chk("R1 rts_o", rts_o, 1);
        stat_chk("R1 status", 1, 1);
        host_rd(2'd2, d); chk("R1 control", d, 0);
        host_rd(2'd3, d); chk("R1 divisor", d, 103);
        // R12 divisor
        host_wr(2'd3, DIV); host_rd(2'd3, d); chk("R12 divisor", d, DIV);
        // R2 single byte
        send(8'hA5, 1);
        stat_chk("R2 status avail", 1, 1);
        host_rd(2'd0, d); chk("R2 data", d, mq.pop_front());
        stat_chk("R2 status empty", 1, 1);
        // R3 fill queue, R9 handshake off
        foreach (d_arr[i]) send(d_arr[i], 1);
        stat_chk("R3 status full", 1, 1);
        chk("R9 rts handshake off", rts_o, 1);
        host_wr(2'd2, 8'h04); @(negedge clk);
        chk("R9 rts full", rts_o, 0);
        // R4 overrun
        send(8'h55, 1);
        stat_chk("R4 overrun set", 1, 1);
        stat_chk("R4 overrun cleared", 1, 1);
        for (int i = 0; i < 4; i++) begin
            host_rd(2'd0, d); chk("R3 order", d, mq.pop_front());
        end
        @(negedge clk); chk("R9 rts released", rts_o, 1);
        host_wr(2'd2, 8'h00);
        // R5 framing error
        send(8'h3C, 0);
        stat_chk("R5 frame set", 1, 1);
        stat_chk("R5 frame cleared", 1, 1);
        // R11 empty read
        host_rd(2'd0, d); chk("R11 empty data", d, 0);
        stat_chk("R11 status unchanged", 1, 1);
        // R8 interrupt sources
        host_wr(2'd2, 8'h01); @(negedge clk); chk("R8 irq rx empty", irq_o, 0);
        send(8'hFF, 1); chk("R8 irq rx data", irq_o, 1);
        host_rd(2'd0, d); chk("R2 data ones", d, mq.pop_front());
        @(negedge clk); chk("R8 irq rx drained", irq_o, 0);
        host_wr(2'd2, 8'h02); @(negedge clk); chk("R8 irq tx empty", irq_o, 1);
        host_wr(2'd2, 8'h00); @(negedge clk); chk("R8 irq disabled", irq_o, 0);
        // R6 double buffering, R7 ignored write
        fork
            begin get_tx(b0, t0); get_tx(b1, t1); end
            begin
                host_wr(2'd0, 8'h96); repeat (8) @(negedge clk);
                stat_chk("R6 holding free", 1, 0);
                host_wr(2'd0, 8'h3A);
                stat_chk("R6 holding full", 0, 0);
                host_wr(2'd0, 8'hFF);
            end
        join
        chk("R6 first byte", b0, 8'h96);
        chk("R7 second byte kept", b1, 8'h3A);
        chk("R6 back to back", (t1 - t0 >= 10*BIT - 6 && t1 - t0 <= 10*BIT + 6), 1);
        hi = 1;
        repeat (12 * BIT) begin @(negedge clk); if (tx_o !== 1'b1) hi = 0; end
        chk("R7 no third frame", hi, 1);
        // R10 clear-to-send gating
        host_wr(2'd2, 8'h04); cts_i = 0; repeat (3) @(negedge clk);
        host_wr(2'd0, 8'hC3);
        hi = 1;
        repeat (3 * BIT) begin @(negedge clk); if (tx_o !== 1'b1) hi = 0; end
        chk("R10 held while cts low", hi, 1);
        stat_chk("R10 holding still full", 0, 0);
        fork
            get_tx(b0, t0);
            begin repeat (5) @(negedge clk); cts_i = 1; end
        join
        chk("R10 sent after cts", b0, 8'hC3);
        host_wr(2'd2, 8'h00); cts_i = 0; repeat (3) @(negedge clk);
        fork
            get_tx(b0, t0);
            host_wr(2'd0, 8'h5A);
        join
        chk("R10 cts ignored when off", b0, 8'h5A);
        cts_i = 1;
    endtask

    logic [7:0] d_arr [4] = '{8'h11, 8'h22, 8'h33, 8'h44};

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule